// File: doc/BRIEF.md
# Wide Access Line Fragmenter

This block takes one memory access of arbitrary length and breaks it into a series of requests that never cross a cache-line boundary. A request carries a start address, a total byte count, an optional per-byte enable mask, a direction bit and qualifiers for exclusive (load-linked/store-conditional), swap, locked read-modify-write and prefetch operations. For every line the access touches, the block works out the piece's address, its byte count and its share of the enable mask. It then offers that piece downstream over a valid/ready handshake.

Only one piece is in flight at a time. After each handshake the block waits for a response that reports success or a fault before it moves on. A piece whose enables are all clear is dropped silently. A write that faults ends the access on the spot. A read that faults keeps going and reports the fault at the end. When the access is over, a one-cycle completion pulse reports the fault status and whether the request was rejected as malformed. A new request is taken only while the block is idle.

Top module: `wide_access_fragmenter`

## Requirements
- R1: Each issued fragment starts where the previous line piece ended, and its size is the smaller of the bytes still outstanding and LINE_BYTES minus the address offset within the line. The first piece starts at `req_addr`.
- R2: With `req_mask_en`=1, bit i of `frag_mask` equals bit (c+i) of `req_mask`, where c is the number of access bytes that precede the fragment and bit j of `req_mask` enables byte j of the access. Bits at index `frag_size` and above are zero.
- R3: A line piece whose mask slice is all zero is not issued and is not a fault. `frag_idx` counts the issued fragments from 0. `frag_last` is 1 exactly when the fragment's bytes reach the end of the access. An access with no enabled byte completes with `done_fault`=0.
- R4: With `req_mask_en`=0, every line piece is issued, and `frag_mask` has its low `frag_size` bits set.
- R5: When a write fragment gets `rsp_fault`=1, no further fragment is issued, and the completion reports `done_fault`=1.
- R6: When a read fragment gets `rsp_fault`=1, the remaining fragments are still issued, and the completion reports `done_fault`=1.
- R7: If `req_prefetch`=1, a fault is reported on completion as `done_fault`=0.
- R8: An exclusive or swap request whose size exceeds the first line piece is rejected. It completes with `done_error`=1 and issues no fragment.
- R9: A locked read-modify-write write that has `req_mask_en`=1 is rejected in the same way.
- R10: A request is rejected in the same way if its size is 0, if its size exceeds MAX_BYTES, or if its mask is enabled and has a set bit at an index at or above the size.
- R11: While `frag_valid`=1 and `frag_ready`=0, the fragment fields hold steady. `done_valid` is high for one cycle, and `req_ready` is 1 in the cycle after it.
- R12: In reset, `req_ready`=1, `frag_valid`=0 and `done_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | CNT_W | Total bytes of the access |
| req_mask_en | input | 1 | Byte-enable mask present |
| req_mask | input | MAX_BYTES | Per-byte enables, bit j = byte j of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_llsc | input | 1 | Exclusive load-linked/store-conditional access |
| req_swap | input | 1 | Swap access |
| req_lock_rmw | input | 1 | Locked read-modify-write access |
| req_prefetch | input | 1 | Prefetch access |
| frag_valid | output | 1 | Fragment offered |
| frag_ready | input | 1 | Fragment accepted |
| frag_addr | output | ADDR_W | Fragment start address |
| frag_size | output | FRAG_W | Fragment byte count |
| frag_mask | output | LINE_BYTES | Fragment enables, bit 0 = first fragment byte |
| frag_idx | output | IDX_W | Issued-fragment index from 0 |
| frag_last | output | 1 | Fragment reaches end of access |
| rsp_valid | input | 1 | Response for the outstanding fragment |
| rsp_fault | input | 1 | Response reports a fault |
| done_valid | output | 1 | Access complete (one cycle) |
| done_fault | output | 1 | Access faulted |
| done_error | output | 1 | Request was rejected as malformed |

## Verification
Aligned, misaligned and single-byte accesses, as well as accesses of the full 256-byte size, show whether the piece sizes are computed correctly at both ends of the access. Dense masks, sparse masks and masks with a single set byte separate real fragments from skipped ones, and they show whether the index and last flag still follow the issued series. Faults are injected at random fragment positions, in both directions and with and without prefetch, to tell stop-on-write from continue-on-read. Requests built to break the exclusive, swap, locked and mask-length rules confirm that each one is rejected without any fragment being issued.

// File: rtl/wfrag_pkg.sv
package wfrag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FRAG = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } wfrag_state_e;
endpackage

// File: rtl/wfrag_geom.sv
// Piece geometry: size of the current line piece and its enable slice.
module wfrag_geom #(
  parameter  int LINE_BYTES = 64,
  parameter  int MAX_BYTES  = 256,
  localparam int OFS_W      = $clog2(LINE_BYTES),
  localparam int CNT_W      = $clog2(MAX_BYTES + 1),
  localparam int FRAG_W     = $clog2(LINE_BYTES + 1)
) (
  input  logic [OFS_W-1:0]      line_ofs,
  input  logic [CNT_W-1:0]      remaining,
  input  logic [CNT_W-1:0]      consumed,
  input  logic                  mask_en,
  input  logic [MAX_BYTES-1:0]  mask,
  output logic [FRAG_W-1:0]     piece_size,
  output logic [LINE_BYTES-1:0] slice,
  output logic                  any_set,
  output logic [CNT_W-1:0]      rem_after
);
  logic [FRAG_W-1:0]     room;
  logic [LINE_BYTES-1:0] window;

  always_comb begin
    room = FRAG_W'(LINE_BYTES) - FRAG_W'(line_ofs);
    if (remaining < CNT_W'(room)) piece_size = FRAG_W'(remaining);
    else                          piece_size = room;
  end

  assign window = LINE_BYTES'(mask >> consumed);

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_slice
    assign slice[g] = (FRAG_W'(g) < piece_size) && (!mask_en || window[g]);
  end

  assign any_set   = |slice;
  assign rem_after = remaining - CNT_W'(piece_size);
endmodule

// File: rtl/wfrag_check.sv
// Request legality: decides at acceptance whether a request is malformed.
module wfrag_check #(
  parameter  int LINE_BYTES = 64,
  parameter  int MAX_BYTES  = 256,
  localparam int OFS_W      = $clog2(LINE_BYTES),
  localparam int CNT_W      = $clog2(MAX_BYTES + 1),
  localparam int FRAG_W     = $clog2(LINE_BYTES + 1)
) (
  input  logic [OFS_W-1:0]     start_ofs,
  input  logic [CNT_W-1:0]     size,
  input  logic                 mask_en,
  input  logic [MAX_BYTES-1:0] mask,
  input  logic                 write,
  input  logic                 llsc,
  input  logic                 swap,
  input  logic                 lock_rmw,
  output logic                 illegal
);
  logic [FRAG_W-1:0]    first_room;
  logic [MAX_BYTES-1:0] in_range;
  logic                 bad_size, spans, stray, bad_atomic, bad_lock;

  assign first_room = FRAG_W'(LINE_BYTES) - FRAG_W'(start_ofs);

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_range
    assign in_range[g] = CNT_W'(g) < size;
  end

  assign bad_size   = (size == '0) || (size > CNT_W'(MAX_BYTES));
  assign spans      = size > CNT_W'(first_room);
  assign bad_atomic = (llsc || swap) && spans;
  assign bad_lock   = lock_rmw && write && mask_en;
  assign stray      = mask_en && (|(mask & ~in_range));
  assign illegal    = bad_size || bad_atomic || bad_lock || stray;
endmodule

// File: rtl/wfrag_ctrl.sv
// Sequencer: walks the access line by line, one fragment outstanding.
module wfrag_ctrl
  import wfrag_pkg::*;
#(
  parameter  int LINE_BYTES = 64,
  parameter  int MAX_BYTES  = 256,
  parameter  int ADDR_W     = 32,
  localparam int CNT_W      = $clog2(MAX_BYTES + 1),
  localparam int FRAG_W     = $clog2(LINE_BYTES + 1),
  localparam int NFRAG      = MAX_BYTES / LINE_BYTES + 1,
  localparam int IDX_W      = (NFRAG > 1) ? $clog2(NFRAG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [CNT_W-1:0]     req_size,
  input  logic                 req_mask_en,
  input  logic [MAX_BYTES-1:0] req_mask,
  input  logic                 req_write,
  input  logic                 req_prefetch,
  input  logic                 req_illegal,
  input  logic [FRAG_W-1:0]    geo_size,
  input  logic                 geo_any,
  input  logic [CNT_W-1:0]     geo_rem_after,
  input  logic                 frag_ready,
  input  logic                 rsp_valid,
  input  logic                 rsp_fault,
  output logic                 req_ready,
  output logic                 frag_valid,
  output logic [IDX_W-1:0]     frag_idx,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic [CNT_W-1:0]     remaining,
  output logic [CNT_W-1:0]     consumed,
  output logic                 mask_en_q,
  output logic [MAX_BYTES-1:0] mask_q,
  output logic                 done_valid,
  output logic                 done_fault,
  output logic                 done_error
);
  wfrag_state_e state, state_n;
  logic write_q, pref_q, fault_q, err_q;
  logic load_en, adv_en, hs_en, flt_en;

  // next-state and enables
  always_comb begin
    state_n = state;
    load_en = 1'b0;
    adv_en  = 1'b0;
    hs_en   = 1'b0;
    flt_en  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          load_en = 1'b1;
          state_n = req_illegal ? ST_DONE : ST_FRAG;
        end
      end
      ST_FRAG: begin
        if (!geo_any) begin
          adv_en = 1'b1;
          if (geo_rem_after == '0) state_n = ST_DONE;
        end else if (frag_ready) begin
          hs_en   = 1'b1;
          state_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          flt_en = rsp_fault;
          if (rsp_fault && write_q) begin
            state_n = ST_DONE;
          end else begin
            adv_en  = 1'b1;
            state_n = (geo_rem_after == '0) ? ST_DONE : ST_FRAG;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      remaining <= '0;
      consumed  <= '0;
      mask_en_q <= 1'b0;
      mask_q    <= '0;
      write_q   <= 1'b0;
      pref_q    <= 1'b0;
      fault_q   <= 1'b0;
      err_q     <= 1'b0;
      frag_idx  <= '0;
    end else begin
      state <= state_n;
      if (load_en) begin
        cur_addr  <= req_addr;
        remaining <= req_size;
        consumed  <= '0;
        mask_en_q <= req_mask_en;
        mask_q    <= req_mask;
        write_q   <= req_write;
        pref_q    <= req_prefetch;
        fault_q   <= 1'b0;
        err_q     <= req_illegal;
        frag_idx  <= '0;
      end else begin
        if (adv_en) begin
          cur_addr  <= cur_addr + ADDR_W'(geo_size);
          remaining <= geo_rem_after;
          consumed  <= consumed + CNT_W'(geo_size);
        end
        if (hs_en)  frag_idx <= frag_idx + 1'b1;
        if (flt_en) fault_q  <= 1'b1;
      end
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign frag_valid = (state == ST_FRAG) && geo_any;
  assign done_valid = (state == ST_DONE);
  assign done_fault = fault_q && !pref_q;
  assign done_error = err_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && !frag_ready |=> frag_valid && $stable(cur_addr) && $stable(frag_idx)); // R11
  AST_WRITE_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) && rsp_valid && rsp_fault && write_q |=> done_valid && !frag_valid); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready); // R11
  AST_ILLEGAL_NO_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_illegal |=> done_valid && done_error && !frag_valid); // R8
endmodule

// File: rtl/wide_access_fragmenter.sv
module wide_access_fragmenter #(
  parameter  int LINE_BYTES = 64,
  parameter  int MAX_BYTES  = 256,
  parameter  int ADDR_W     = 32,
  localparam int OFS_W      = $clog2(LINE_BYTES),
  localparam int CNT_W      = $clog2(MAX_BYTES + 1),
  localparam int FRAG_W     = $clog2(LINE_BYTES + 1),
  localparam int NFRAG      = MAX_BYTES / LINE_BYTES + 1,
  localparam int IDX_W      = (NFRAG > 1) ? $clog2(NFRAG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [CNT_W-1:0]      req_size,
  input  logic                  req_mask_en,
  input  logic [MAX_BYTES-1:0]  req_mask,
  input  logic                  req_write,
  input  logic                  req_llsc,
  input  logic                  req_swap,
  input  logic                  req_lock_rmw,
  input  logic                  req_prefetch,
  output logic                  frag_valid,
  input  logic                  frag_ready,
  output logic [ADDR_W-1:0]     frag_addr,
  output logic [FRAG_W-1:0]     frag_size,
  output logic [LINE_BYTES-1:0] frag_mask,
  output logic [IDX_W-1:0]      frag_idx,
  output logic                  frag_last,
  input  logic                  rsp_valid,
  input  logic                  rsp_fault,
  output logic                  done_valid,
  output logic                  done_fault,
  output logic                  done_error
);
  logic                 illegal;
  logic [CNT_W-1:0]     remaining, consumed, rem_after;
  logic                 mask_en_q, any_set;
  logic [MAX_BYTES-1:0] mask_q;

  wfrag_check #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) u_check (
    .start_ofs (req_addr[OFS_W-1:0]),
    .size      (req_size),
    .mask_en   (req_mask_en),
    .mask      (req_mask),
    .write     (req_write),
    .llsc      (req_llsc),
    .swap      (req_swap),
    .lock_rmw  (req_lock_rmw),
    .illegal   (illegal)
  );

  wfrag_geom #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) u_geom (
    .line_ofs   (frag_addr[OFS_W-1:0]),
    .remaining  (remaining),
    .consumed   (consumed),
    .mask_en    (mask_en_q),
    .mask       (mask_q),
    .piece_size (frag_size),
    .slice      (frag_mask),
    .any_set    (any_set),
    .rem_after  (rem_after)
  );

  wfrag_ctrl #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_mask_en   (req_mask_en),
    .req_mask      (req_mask),
    .req_write     (req_write),
    .req_prefetch  (req_prefetch),
    .req_illegal   (illegal),
    .geo_size      (frag_size),
    .geo_any       (any_set),
    .geo_rem_after (rem_after),
    .frag_ready    (frag_ready),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .req_ready     (req_ready),
    .frag_valid    (frag_valid),
    .frag_idx      (frag_idx),
    .cur_addr      (frag_addr),
    .remaining     (remaining),
    .consumed      (consumed),
    .mask_en_q     (mask_en_q),
    .mask_q        (mask_q),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_error    (done_error)
  );

  assign frag_last = (rem_after == '0);

  AST_FRAG_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> (frag_size != '0) &&
                   (int'(frag_addr[OFS_W-1:0]) + int'(frag_size) <= LINE_BYTES)); // R1
  AST_MASK_WITHIN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> ((frag_mask >> frag_size) == '0)); // R2
  AST_IDLE_NO_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !frag_valid && !done_valid); // R12
endmodule

// File: tb/wide_access_fragmenter_bench.sv
module wide_access_fragmenter_bench;
  localparam int LINE = 64;
  localparam int MAXB = 256;
  localparam int AW   = 32;
  localparam int CW   = 9;
  localparam int FW   = 7;
  localparam int IW   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_mask_en, req_write, req_llsc, req_swap;
  logic req_lock_rmw, req_prefetch;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_size;
  logic [MAXB-1:0] req_mask;
  logic frag_valid, frag_ready, frag_last;
  logic [AW-1:0] frag_addr;
  logic [FW-1:0] frag_size;
  logic [LINE-1:0] frag_mask;
  logic [IW-1:0] frag_idx;
  logic rsp_valid, rsp_fault, done_valid, done_fault, done_error;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wide_access_fragmenter u_wide_access_fragmenter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_mask_en(req_mask_en),
    .req_mask(req_mask), .req_write(req_write), .req_llsc(req_llsc),
    .req_swap(req_swap), .req_lock_rmw(req_lock_rmw), .req_prefetch(req_prefetch),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
    .frag_size(frag_size), .frag_mask(frag_mask), .frag_idx(frag_idx),
    .frag_last(frag_last), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .done_valid(done_valid), .done_fault(done_fault), .done_error(done_error)
  );

  task automatic check(input bit ok, input string rq, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", rq, what);
    end
  endtask

  function automatic logic [MAXB-1:0] low_ones(input int n);
    logic [MAXB-1:0] r;
    for (int i = 0; i < MAXB; i++) r[i] = (i < n);
    return r;
  endfunction

  function automatic bit exp_illegal(input logic [AW-1:0] a, input int sz, input bit men,
                                     input logic [MAXB-1:0] m, input bit wr, input bit ll,
                                     input bit sw, input bit lk);
    int room = LINE - int'(a[5:0]);
    if (sz == 0 || sz > MAXB) return 1;
    if ((ll || sw) && sz > room) return 1;
    if (lk && wr && men) return 1;
    if (men && ((m & ~low_ones(sz)) != '0)) return 1;
    return 0;
  endfunction

  function automatic logic [MAXB-1:0] rnd_wide();
    logic [MAXB-1:0] r;
    for (int i = 0; i < MAXB / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // Drive one access, act as downstream, check every fragment and completion.
  task automatic do_access(input logic [AW-1:0] a, input int sz, input bit men,
                           input logic [MAXB-1:0] m, input bit wr, input bit ll,
                           input bit sw, input bit lk, input bit pf, input int fault_at);
    bit ill = exp_illegal(a, sz, men, m, wr, ll, sw, lk);
    int rem = sz;
    int cons = 0;
    int iss = 0;
    bit flt = 0;
    bit stop = 0;
    int t;
    logic [AW-1:0] ca = a;
    string erq = ll || sw ? "R8" : (lk && wr && men) ? "R9" : "R10";
    t = 0;
    while (!req_ready && t < 300) begin @(negedge clk); t++; end
    req_addr = a; req_size = CW'(sz); req_mask_en = men; req_mask = m;
    req_write = wr; req_llsc = ll; req_swap = sw; req_lock_rmw = lk; req_prefetch = pf;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!ill) begin
      while (rem > 0 && !stop) begin
        int fs = LINE - int'(ca[5:0]);
        logic [MAXB-1:0] lo, sh;
        logic [LINE-1:0] es;
        if (rem < fs) fs = rem;
        lo = low_ones(fs);
        sh = m >> cons;
        es = men ? (sh[LINE-1:0] & lo[LINE-1:0]) : lo[LINE-1:0];
        if (es != '0) begin
          t = 0;
          while (!frag_valid && !done_valid && t < 300) begin @(negedge clk); t++; end
          check(frag_valid, "R3", $sformatf("fragment missing: got none, expected addr %h", ca));
          if (!frag_valid) return;
          check(frag_addr == ca && int'(frag_size) == fs, "R1",
                $sformatf("addr/size %h/%0d expected %h/%0d", frag_addr, frag_size, ca, fs));
          check(frag_mask == es, men ? "R2" : "R4",
                $sformatf("mask %h expected %h", frag_mask, es));
          check(int'(frag_idx) == iss && frag_last == (rem == fs), "R3",
                $sformatf("idx/last %0d/%0b expected %0d/%0b", frag_idx, frag_last, iss, rem == fs));
          begin
            int hold = int'($urandom % 3);
            if (hold > 0) begin
              repeat (hold) @(negedge clk);
              check(frag_valid && frag_addr == ca && int'(frag_idx) == iss, "R11",
                    $sformatf("stall hold v/addr %0b/%h expected 1/%h", frag_valid, frag_addr, ca));
            end
          end
          frag_ready = 1'b1;
          @(negedge clk);
          frag_ready = 1'b0;
          repeat (int'($urandom % 3)) @(negedge clk);
          rsp_valid = 1'b1;
          rsp_fault = (iss == fault_at);
          @(negedge clk);
          rsp_valid = 1'b0;
          if (iss == fault_at) begin
            flt = 1;
            if (wr) stop = 1;
          end
          rsp_fault = 1'b0;
          iss++;
        end
        ca = ca + AW'(fs);
        cons += fs;
        rem -= fs;
      end
    end
    t = 0;
    while (!done_valid && t < 300) begin
      if (frag_valid) begin
        check(0, wr && flt ? "R5" : "R3", $sformatf("extra fragment at %h, expected none", frag_addr));
        return;
      end
      @(negedge clk); t++;
    end
    check(done_valid, "R11", "completion missing: got 0 expected 1");
    check(done_error == ill, erq, $sformatf("done_error %0b expected %0b", done_error, ill));
    check(done_fault == (flt && !pf), pf ? "R7" : (wr ? "R5" : "R6"),
          $sformatf("done_fault %0b expected %0b", done_fault, flt && !pf));
    @(negedge clk);
    check(!done_valid && req_ready, "R11",
          $sformatf("after done v/ready %0b/%0b expected 0/1", done_valid, req_ready));
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0;
    req_valid = 0; req_addr = '0; req_size = '0; req_mask_en = 0; req_mask = '0;
    req_write = 0; req_llsc = 0; req_swap = 0; req_lock_rmw = 0; req_prefetch = 0;
    frag_ready = 0; rsp_valid = 0; rsp_fault = 0;
    repeat (3) @(negedge clk);
    check(req_ready && !frag_valid && !done_valid, "R12",
          $sformatf("reset ready/fv/dv %0b/%0b/%0b expected 1/0/0", req_ready, frag_valid, done_valid));
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    do_access(32'h1000, 1,   0, '0, 0, 0, 0, 0, 0, -1);                 // R1 single byte
    do_access(32'h1000, 64,  0, '0, 1, 0, 0, 0, 0, -1);                 // R4 one full line
    do_access(32'h203f, 256, 0, '0, 0, 0, 0, 0, 0, -1);                 // R1 five pieces
    do_access(32'h3010, 200, 1, '0, 1, 0, 0, 0, 0, -1);                 // R3 nothing enabled
    do_access(32'h4000, 192, 1, low_ones(140) & ~low_ones(130), 0, 0, 0, 0, 0, -1); // R3 skip
    do_access(32'h5008, 8,   0, '0, 1, 1, 0, 0, 0, -1);                 // R8 fits
    do_access(32'h503c, 8,   0, '0, 1, 1, 0, 0, 0, -1);                 // R8 spans
    do_access(32'h5030, 32,  0, '0, 0, 0, 1, 0, 0, -1);                 // R8 swap spans
    do_access(32'h6000, 16,  1, low_ones(16), 1, 0, 0, 1, 0, -1);       // R9 masked locked write
    do_access(32'h6000, 16,  0, '0, 1, 0, 0, 1, 0, -1);                 // R9 unmasked locked ok
    do_access(32'h7000, 20,  1, low_ones(21), 0, 0, 0, 0, 0, -1);       // R10 stray mask bit
    do_access(32'h7000, 0,   0, '0, 0, 0, 0, 0, 0, -1);                 // R10 zero size
    do_access(32'h7000, 257, 0, '0, 0, 0, 0, 0, 0, -1);                 // R10 oversize
    do_access(32'h8020, 200, 0, '0, 1, 0, 0, 0, 0, 1);                  // R5 write fault
    do_access(32'h8020, 200, 0, '0, 0, 0, 0, 0, 0, 1);                  // R6 read fault
    do_access(32'h8020, 200, 0, '0, 1, 0, 0, 0, 1, 0);                  // R7 prefetch fault

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a = $urandom;
      int sz = (($urandom % 16) == 0) ? int'($urandom % 300) : 1 + int'($urandom % MAXB);
      bit men = $urandom % 2;
      int dens = int'($urandom % 3);
      logic [MAXB-1:0] m = rnd_wide();
      int fa = (($urandom % 3) == 0) ? int'($urandom % 5) : -1;
      if (dens == 1) m = m & rnd_wide() & rnd_wide() & rnd_wide() & rnd_wide();
      if (dens == 2) begin m = '0; m[$urandom % MAXB] = 1'b1; end
      if (($urandom % 10) != 0) m = m & low_ones(sz);
      do_access(a, sz, men, m, 1'($urandom % 2), (($urandom % 8) == 0),
                (($urandom % 8) == 0), (($urandom % 6) == 0), (($urandom % 8) == 0), fa);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule